// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Status Register

This block is a 64-bit integer arithmetic and logic unit that also holds a 32-bit program status register. Each issued operation takes two operands, an operation code, an operand-size select (32 or 64 bits) and a flag-update request. The result comes out registered, together with a write-back strobe. The four condition flags in the status register change only when the operation asks for them. A compare always updates the flags and never requests a write-back.

The low byte of the status register holds control bits. A separate write port, gated by a privilege input, loads that byte. Writes made without privilege are dropped. Bits 27 down to 8 of the status register are reserved and always read as zero.

Top module: `flag_alu`

## Requirements
- R1: After reset the result output is zero, the write-back strobe is low, and the status output reads {4'b0000, 20'b0, CTRL_RST}. Status bits 27:8 read zero at all times.
- R2: When `issue_i` is high, the result appears on `result_o` on the next rising clock edge. Operation codes are ADD=0, SUB=1, CMP=2, OR=3, AND=4 and XOR=5. For ADD, SUB, OR, AND and XOR, `wb_en_o` is high for that one cycle.
- R3: Flags sit in status bits 31 (N), 30 (Z), 29 (C) and 28 (V). They are loaded only when `setf_i` is high or the operation is a compare. Otherwise they keep their value.
- R4: On a flag update, N equals the top bit of the result at the selected size, and Z is 1 exactly when that result is zero.
- R5: For an addition, C is the carry out of the top bit at the selected size.
- R6: For a subtraction or compare, C is 1 when no borrow occurs and 0 when a borrow occurs.
- R7: For an arithmetic operation, V is 1 exactly when signed overflow occurs at the selected size.
- R8: A compare computes a minus b and loads the flags even when `setf_i` is low. It shows the difference on `result_o` but keeps `wb_en_o` low.
- R9: OR, AND and XOR produce the bitwise result. With flag update, they set N and Z from the result and clear C and V.
- R10: The status low byte loads `ctl_data_i` only when `ctl_we_i` and `priv_i` are both high. A write without privilege leaves it unchanged.
- R11: When `wide_i` is 0, only operand bits 31:0 are used, flags come from bits 31 and 32, and `result_o[63:32]` is zero.
- R12: Codes 6 and 7 are reserved. They give a zero result, no write-back and no flag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation valid this cycle |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 = 64-bit, 0 = 32-bit operation |
| setf_i | input | 1 | Request flag update |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| priv_i | input | 1 | Privileged writer indication |
| ctl_we_i | input | 1 | Control byte write request |
| ctl_data_i | input | 8 | Control byte write data |
| result_o | output | 64 | Registered result |
| wb_en_o | output | 1 | Result write-back strobe |
| status_o | output | 32 | Status register |

## Verification
The in-RTL assertions check, on every cycle, the properties that hold regardless of data values:
- flags are held when no update is requested;
- a compare never writes back;
- the upper result half is zero in 32-bit mode;
- logic operations clear C and V;
- the control byte is guarded by privilege;
- the reserved status bits stay zero.

The actual carry, borrow, overflow, negative and zero values for specific operand pairs can only be shown by the bench's vectors. The same holds for the zero-extension of 32-bit sums, the privileged load of the control byte, and the return to the reset state.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_OR  = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide_sum;

    always_comb begin
        b_eff    = sub ? ~b : b;
        wide_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum      = wide_sum[W-1:0];
        cout     = wide_sum[W];
        // signed overflow: both inputs agree in sign, result differs
        ovf      = (a[W-1] == b_eff[W-1]) && (wide_sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 64
) (
    input  alu_pkg::alu_op_e op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);
    import alu_pkg::*;

    always_comb begin
        unique case (op)
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
    parameter int W = 64
) (
    input  logic [W-1:0]  res,
    input  logic          wide,
    input  logic          is_logic,
    input  logic          carry,
    input  logic          ovf,
    output alu_pkg::nzcv_t flags
);
    localparam int HW = W / 2;

    always_comb begin
        flags.n = wide ? res[W-1] : res[HW-1];
        flags.z = wide ? (res == '0) : (res[HW-1:0] == '0);
        flags.c = is_logic ? 1'b0 : carry;
        flags.v = is_logic ? 1'b0 : ovf;
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
    parameter int         DATA_W   = 64,
    parameter logic [7:0] CTRL_RST = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic              setf_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              priv_i,
    input  logic              ctl_we_i,
    input  logic [7:0]        ctl_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wb_en_o,
    output logic [31:0]       status_o
);
    import alu_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int STAT_W = 32;
    localparam int RSV_W  = STAT_W - 4 - 8;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wb_en;
        nzcv_t             flags;
        logic [7:0]        ctl;
    } state_t;

    state_t st_d, st_q;

    alu_op_e           op;
    logic              known, is_arith, is_logic, is_sub, upd_flags;
    logic [DATA_W-1:0] sum_full, logic_full, res_sel;
    logic [HALF_W-1:0] sum_half;
    logic              c_full, v_full, c_half, v_half;
    nzcv_t             flags_new;

    assign op       = alu_op_e'(op_i);
    assign known    = (op_i <= 3'd5);
    assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
    assign is_arith = known && ((op == OP_ADD) || is_sub);
    assign is_logic = known && !is_arith;

    alu_addsub #(.W(DATA_W)) u_add_full (
        .a(a_i), .b(b_i), .sub(is_sub),
        .sum(sum_full), .cout(c_full), .ovf(v_full)
    );

    alu_addsub #(.W(HALF_W)) u_add_half (
        .a(a_i[HALF_W-1:0]), .b(b_i[HALF_W-1:0]), .sub(is_sub),
        .sum(sum_half), .cout(c_half), .ovf(v_half)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .op(op), .a(a_i), .b(b_i), .y(logic_full)
    );

    always_comb begin
        if (!known)
            res_sel = '0;
        else if (is_arith)
            res_sel = wide_i ? sum_full : {{HALF_W{1'b0}}, sum_half};
        else
            res_sel = wide_i ? logic_full
                             : {{HALF_W{1'b0}}, logic_full[HALF_W-1:0]};
    end

    alu_flag_gen #(.W(DATA_W)) u_flags (
        .res(res_sel),
        .wide(wide_i),
        .is_logic(is_logic),
        .carry(wide_i ? c_full : c_half),
        .ovf(wide_i ? v_full : v_half),
        .flags(flags_new)
    );

    assign upd_flags = issue_i && known && (setf_i || (op == OP_CMP));

    always_comb begin
        st_d       = st_q;
        st_d.wb_en = issue_i && known && (op != OP_CMP);
        if (issue_i)
            st_d.result = res_sel;
        if (upd_flags)
            st_d.flags = flags_new;
        if (ctl_we_i && priv_i)
            st_d.ctl = ctl_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.result <= '0;
            st_q.wb_en  <= 1'b0;
            st_q.flags  <= '0;
            st_q.ctl    <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign wb_en_o  = st_q.wb_en;
    assign status_o = {st_q.flags, {RSV_W{1'b0}}, st_q.ctl};

    // R3: flags hold unless an update was requested
    p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_i && (setf_i || op_i == 3'd2)) |=> $stable(status_o[31:28]));

    // R8: compare never strobes write-back
    p_cmp_nowb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == 3'd2) |=> !wb_en_o);

    // R9: logic ops with flag update clear C and V
    p_logic_cv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && setf_i && op_i >= 3'd3 && op_i <= 3'd5)
        |=> (status_o[29:28] == 2'b00));

    // R10: control byte changes only through a privileged write
    p_ctl_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we_i && priv_i) |=> $stable(status_o[7:0]));

    // R11: upper half zero after a 32-bit operation
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !wide_i) |=> (result_o[DATA_W-1:HALF_W] == '0));

    // R1: reserved status bits read zero
    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[27:8] == '0);

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam logic [7:0] CRST = 8'hC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b0, setf_i = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic        priv_i = 1'b0, ctl_we_i = 1'b0;
    logic [7:0]  ctl_data_i = '0;
    logic [63:0] result_o;
    logic        wb_en_o;
    logic [31:0] status_o;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu u_flag_alu (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .wide_i(wide_i), .setf_i(setf_i), .a_i(a_i), .b_i(b_i),
        .priv_i(priv_i), .ctl_we_i(ctl_we_i), .ctl_data_i(ctl_data_i),
        .result_o(result_o), .wb_en_o(wb_en_o), .status_o(status_o)
    );

    // {op, wide, setf, a, b, expected result, expected wb, expected NZCV}
    localparam logic [201:0] VEC [NVEC] = '{
        {3'd0,1'b1,1'b0,64'd5,64'd7,64'd12,1'b1,4'b0000},
        {3'd0,1'b0,1'b1,64'hAAAAAAAA,64'hAAAAAAAA,64'h55555554,1'b1,4'b0011},
        {3'd0,1'b1,1'b0,64'd1,64'd1,64'd2,1'b1,4'b0011},
        {3'd1,1'b0,1'b1,64'd0,64'hFF,64'hFFFFFF01,1'b1,4'b1000},
        {3'd1,1'b1,1'b1,64'd5,64'd5,64'd0,1'b1,4'b0110},
        {3'd0,1'b1,1'b1,64'h7FFFFFFFFFFFFFFF,64'd1,64'h8000000000000000,1'b1,4'b1001},
        {3'd0,1'b1,1'b1,64'hFFFFFFFFFFFFFFFF,64'd1,64'd0,1'b1,4'b0110},
        {3'd2,1'b0,1'b0,64'hDEAD000000000004,64'd3,64'd1,1'b0,4'b0010},
        {3'd3,1'b1,1'b1,64'hF0,64'h0F,64'hFF,1'b1,4'b0000},
        {3'd4,1'b1,1'b1,64'h80000000000000FF,64'hFFFF000000000000,64'h8000000000000000,1'b1,4'b1000},
        {3'd5,1'b0,1'b1,64'h123456789ABCDEF0,64'h9ABCDEF0,64'd0,1'b1,4'b0100},
        {3'd1,1'b0,1'b1,64'h80000000,64'd1,64'h7FFFFFFF,1'b1,4'b0011},
        {3'd1,1'b1,1'b0,64'd10,64'd3,64'd7,1'b1,4'b0011},
        {3'd5,1'b1,1'b0,64'hFF,64'h0F,64'hF0,1'b1,4'b0011},
        {3'd7,1'b1,1'b1,64'd1,64'd1,64'd0,1'b0,4'b0011},
        {3'd0,1'b1,1'b1,64'h8000000000000000,64'h8000000000000000,64'd0,1'b1,4'b0111}
    };

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic w, input logic sf,
                          input logic [63:0] a, input logic [63:0] b);
        op_i = op; wide_i = w; setf_i = sf; a_i = a; b_i = b; issue_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] ctl_exp;
        ctl_exp = CRST;
        repeat (3) @(negedge clk);
        // R1 reset state
        check64("R1 result", result_o, 64'd0);
        check64("R1 wb", {63'd0, wb_en_o}, 64'd0);
        check64("R1 status", {32'd0, status_o}, {32'd0, 4'b0000, 20'd0, CRST});
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R8 R9 R11 R12 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [201:0] v;
            v = VEC[i];
            run_op(v[201:199], v[198], v[197], v[196:133], v[132:69]);
            check64($sformatf("R2/R11 result vec%0d", i), result_o, v[68:5]);
            check64($sformatf("R8/R12 wb vec%0d", i), {63'd0, wb_en_o}, {63'd0, v[4]});
            check64($sformatf("R3-flags R4 R5 R6 R7 R9 status vec%0d", i),
                    {32'd0, status_o}, {32'd0, v[3:0], 20'd0, ctl_exp});
        end

        // R10: unprivileged write ignored
        ctl_data_i = 8'h1F; ctl_we_i = 1'b1; priv_i = 1'b0;
        @(posedge clk); @(negedge clk);
        ctl_we_i = 1'b0;
        check64("R10 unpriv ignored", {56'd0, status_o[7:0]}, {56'd0, ctl_exp});
        // R10: privileged write loads, flags untouched
        ctl_we_i = 1'b1; priv_i = 1'b1;
        @(posedge clk); @(negedge clk);
        ctl_we_i = 1'b0; priv_i = 1'b0;
        ctl_exp = 8'h1F;
        check64("R10 priv write", {32'd0, status_o}, {32'd0, 4'b0111, 20'd0, ctl_exp});

        // R11: 32-bit add ignores upper operand bits, carry from bit 32
        run_op(3'd0, 1'b0, 1'b1, 64'hFFFF0000FFFFFFFF, 64'h00FF000000000001);
        check64("R11 half add", result_o, 64'd0);
        check64("R11 half flags", {60'd0, status_o[31:28]}, {60'd0, 4'b0110});

        // R1: reset mid-run restores state
        rst_n = 1'b0;
        @(negedge clk);
        check64("R1 rerst status", {32'd0, status_o}, {32'd0, 4'b0000, 20'd0, CRST});
        check64("R1 rerst result", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule